// File: doc/BRIEF.md
# Interrupt Pending and End-of-Interrupt Tracker

This block sits between a bank of interrupt request lines and a delivery scanner. It holds a small redirection table with one 32-bit entry per pin, the pending bit of every pin, and the remote-acknowledge flag that a level-sensitive pin raises once its interrupt has been handed on. When new work appears it raises a service request toward the scanner. The scanner reports each pin it delivered, and the block updates that pin's state.

An end-of-interrupt (EOI) strobe carries a vector. Every level-sensitive entry whose vector matches and whose acknowledge flag is set gets that flag cleared. If such a pin is unmasked and its line is still active, the block asks for service again at once. A per-pin counter tracks these back-to-back re-assertions. When it reaches a limit, that re-service waits on a single shared countdown, so a stuck line cannot hold the scanner busy forever. Software reads and writes entries through a side port.

The service request is a valid/ready handshake. `svc_valid_o` rises in the cycle after any request and stays high until the scanner takes it with `svc_ready_i`. Requests that arrive while it is pending merge into it, and no request is lost while the scanner holds off. All other pins are plain strobes and levels.

Top module: `irq_eoi_tracker`

## Requirements
- R1: Input line 0 and input line 2 together (OR) drive pin 2. Every other input line k below NUM_PINS drives pin k. Pin 0 is never pending. Input lines at index NUM_PINS or above have no effect.
- R2: On a pin whose level bit (entry bit 13) is 1, the pending bit follows the line one cycle later. A rising line requests service only if the acknowledge flag (bit 12) is 0.
- R3: On a pin whose level bit is 0, a rising line sets pending and requests service only if the mask bit (bit 14) is 0. A rise while masked is dropped and is not remembered.
- R4: A delivery report for a pending, unmasked pin clears pending on an edge pin and sets the acknowledge flag on a level pin. A report for any other pin changes nothing.
- R5: An EOI clears the acknowledge flag only on entries whose vector (bits 7:0) equals the EOI vector, whose level bit is 1 and whose flag is set. All other entries are untouched.
- R6: When an EOI clears a flag on an unmasked pin that is still pending, service is requested in the next cycle and that pin's counter increments.
- R7: The re-assertion that brings a pin's counter to STORM_LIM resets the counter and requests no service at once. `svc_valid_o` rises exactly DEFER_CYC cycles after that EOI cycle.
- R8: A write to an entry resets that pin's counter. So does an EOI that clears the flag on a masked or non-pending pin.
- R9: One countdown serves all pins. A deferral raised while the countdown is running does not move its deadline.
- R10: Entry layout: vector 7:0, delivery type 10:8, destination mode 11, acknowledge flag 12 (read-only), level 13, mask 14, bit 15 reserved (reads 0), destination 31:16. A write keeps the flag, or clears it if the new level bit is 0. A write to an in-range address requests service. Addresses at NUM_PINS or above ignore writes and read 0.
- R11: `svc_valid_o` is set in the cycle after any request. It holds while `svc_ready_i` is low and clears after acceptance unless a new request arrives.
- R12: After reset every entry reads 0x00004000 (masked, edge, vector 0), nothing is pending, and `svc_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_IN | Interrupt request line levels |
| eoi_valid_i | input | 1 | EOI strobe |
| eoi_vec_i | input | 8 | EOI vector |
| dlv_valid_i | input | 1 | Scanner delivery report strobe |
| dlv_pin_i | input | PIN_W | Pin delivered by the scanner |
| cfg_we_i | input | 1 | Table write enable |
| cfg_addr_i | input | PIN_W | Table entry index for read and write |
| cfg_wdata_i | input | 32 | Table write data |
| cfg_rdata_o | output | 32 | Entry at cfg_addr_i (combinational) |
| pend_o | output | NUM_PINS | Pending bit per pin |
| svc_valid_o | output | 1 | Service scan request |
| svc_ready_i | input | 1 | Scanner takes the request |

## Verification
The bench targets line 0 steering to pin 2 and an out-of-range line. A wrong map would leave pin 2 idle or raise a phantom pin. It targets a masked edge that must not be remembered once the pin is unmasked, which a latch-then-gate design would deliver late. It targets an EOI with the wrong vector, which must leave the flag set. It checks that the storm deferral lands exactly DEFER_CYC cycles after its EOI, even when a second pin's storm arrives mid-countdown; a timer that reloads would fire late. It also checks that writes and dead-line EOIs reset the counter, so a design that keeps the old count defers one re-assertion too early.

// File: rtl/iet_pkg.sv
package iet_pkg;

  localparam int ENT_W  = 32;
  localparam int VEC_W  = 8;
  localparam int B_RIRR = 12;
  localparam int B_LVL  = 13;
  localparam int B_MASK = 14;

  // writable bits: everything but the acknowledge flag and the reserved bit
  localparam logic [ENT_W-1:0] ENT_WMASK = 32'hFFFF_6FFF;
  localparam logic [ENT_W-1:0] ENT_RST   = 32'h0000_4000;

  typedef struct packed {
    logic [15:0]      dest;
    logic             rsv;
    logic             mask;
    logic             lvl;
    logic             rirr;
    logic             dmode;
    logic [2:0]       dtype;
    logic [VEC_W-1:0] vec;
  } ent_t;

endpackage

// File: rtl/iet_inmap.sv
module iet_inmap #(
  parameter int NUM_IN   = 26,
  parameter int NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_IN-1:0]   irq_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] rise_o
);

  logic [NUM_PINS-1:0] prev_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    if (p == 0) begin : g_none
      assign lvl_o[p] = 1'b0;
    end else if (p == 2) begin : g_steer
      if (NUM_IN > 2) begin : g_both
        assign lvl_o[p] = irq_i[0] | irq_i[2];
      end else begin : g_zero_only
        assign lvl_o[p] = irq_i[0];
      end
    end else if (p < NUM_IN) begin : g_direct
      assign lvl_o[p] = irq_i[p];
    end else begin : g_absent
      assign lvl_o[p] = 1'b0;
    end
  end

  if (NUM_IN > NUM_PINS) begin : g_hi
    logic hi_lines_unused;
    assign hi_lines_unused = ^irq_i[NUM_IN-1:NUM_PINS];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/iet_pin.sv
module iet_pin
  import iet_pkg::*;
#(
  parameter int STORM_LIM = 10000,
  localparam int CNT_W    = $clog2(STORM_LIM + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic             wr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic             eoi_i,
  input  logic [VEC_W-1:0] eoi_vec_i,
  input  logic             dlv_i,
  output logic [ENT_W-1:0] ent_o,
  output logic             pend_o,
  output logic             req_o,
  output logic             defer_o
);

  ent_t             ent_q, ent_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             eoi_hit, reassert, storm, dlv_hit, in_req, rirr_nx;

  always_comb begin
    eoi_hit  = eoi_i && (ent_q.vec == eoi_vec_i) && ent_q.lvl && ent_q.rirr;
    reassert = eoi_hit && !ent_q.mask && pend_q;
    cnt_inc  = cnt_q + 1'b1;
    storm    = reassert && (cnt_inc == CNT_W'(STORM_LIM));
    dlv_hit  = dlv_i && pend_q && !ent_q.mask;
    in_req   = ent_q.lvl ? (rise_i && !ent_q.rirr) : (rise_i && !ent_q.mask);

    if (eoi_hit)                    rirr_nx = 1'b0;
    else if (dlv_hit && ent_q.lvl)  rirr_nx = 1'b1;
    else                            rirr_nx = ent_q.rirr;

    ent_d      = ent_q;
    ent_d.rirr = rirr_nx;
    if (wr_i) begin
      ent_d      = ent_t'(wdata_i & ENT_WMASK);
      ent_d.rirr = wdata_i[B_LVL] & rirr_nx;
    end

    if (ent_q.lvl) pend_d = lvl_i;
    else           pend_d = (pend_q && !dlv_hit) || (rise_i && !ent_q.mask);

    cnt_d = cnt_q;
    if (wr_i)         cnt_d = '0;
    else if (eoi_hit) cnt_d = (reassert && !storm) ? cnt_inc : '0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ent_q  <= ent_t'(ENT_RST);
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ent_q  <= ent_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ent_o   = ent_q;
  assign pend_o  = pend_q;
  assign req_o   = in_req | (reassert & ~storm) | wr_i;
  assign defer_o = storm;

endmodule

// File: rtl/iet_defer.sv
module iet_defer #(
  parameter int DEFER_CYC = 500000,
  localparam int TW       = $clog2(DEFER_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          defer_i,
  output logic          fire_o,
  output logic          armed_o,
  output logic [TW-1:0] cnt_o
);

  localparam logic [TW-1:0] LOAD = TW'(DEFER_CYC - 1);

  logic          armed_q;
  logic [TW-1:0] cnt_q;

  assign fire_o = armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (fire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (defer_i) begin
      armed_q <= 1'b1;
      cnt_q   <= LOAD;
    end
  end

  assign armed_o = armed_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/irq_eoi_tracker.sv
module irq_eoi_tracker
  import iet_pkg::*;
#(
  parameter int NUM_IN    = 26,
  parameter int NUM_PINS  = 24,
  parameter int STORM_LIM = 10000,
  parameter int DEFER_CYC = 500000,
  localparam int PIN_W    = $clog2(NUM_PINS),
  localparam int TW       = $clog2(DEFER_CYC + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_IN-1:0]   irq_i,
  input  logic                eoi_valid_i,
  input  logic [VEC_W-1:0]    eoi_vec_i,
  input  logic                dlv_valid_i,
  input  logic [PIN_W-1:0]    dlv_pin_i,
  input  logic                cfg_we_i,
  input  logic [PIN_W-1:0]    cfg_addr_i,
  input  logic [ENT_W-1:0]    cfg_wdata_i,
  output logic [ENT_W-1:0]    cfg_rdata_o,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                svc_valid_o,
  input  logic                svc_ready_i
);

  logic [NUM_PINS-1:0] lvl, rise, req_vec, defer_vec, trig_vec;
  logic [ENT_W-1:0]    ent_arr [NUM_PINS];
  logic                tmr_fire, tmr_armed;
  logic [TW-1:0]       tmr_cnt;
  logic                svc_q;

  iet_inmap #(.NUM_IN(NUM_IN), .NUM_PINS(NUM_PINS)) u_inmap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    iet_pin #(.STORM_LIM(STORM_LIM)) u_pin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl[p]),
      .rise_i    (rise[p]),
      .wr_i      (cfg_we_i && (cfg_addr_i == PIN_W'(p))),
      .wdata_i   (cfg_wdata_i),
      .eoi_i     (eoi_valid_i),
      .eoi_vec_i (eoi_vec_i),
      .dlv_i     (dlv_valid_i && (dlv_pin_i == PIN_W'(p))),
      .ent_o     (ent_arr[p]),
      .pend_o    (pend_o[p]),
      .req_o     (req_vec[p]),
      .defer_o   (defer_vec[p])
    );
    assign trig_vec[p] = ent_arr[p][B_LVL];
  end

  iet_defer #(.DEFER_CYC(DEFER_CYC)) u_defer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .defer_i (|defer_vec),
    .fire_o  (tmr_fire),
    .armed_o (tmr_armed),
    .cnt_o   (tmr_cnt)
  );

  always_comb begin
    cfg_rdata_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (cfg_addr_i == PIN_W'(p)) cfg_rdata_o = ent_arr[p];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) svc_q <= 1'b0;
    else         svc_q <= (svc_q & ~svc_ready_i) | (|req_vec) | tmr_fire;
  end

  assign svc_valid_o = svc_q;

endmodule

// File: rtl/iet_chk.sv
module iet_chk #(
  parameter int NUM_IN   = 26,
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5,
  parameter int TW       = 19
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_IN-1:0]   irq_i,
  input logic [NUM_PINS-1:0] pend_o,
  input logic                svc_valid_o,
  input logic                svc_ready_i,
  input logic                cfg_we_i,
  input logic [PIN_W-1:0]    cfg_addr_i,
  input logic [NUM_PINS-1:0] trig_vec,
  input logic                tmr_armed,
  input logic [TW-1:0]       tmr_cnt
);

  localparam int LIMP = (NUM_IN < NUM_PINS) ? NUM_IN : NUM_PINS;
  localparam logic [PIN_W:0] NP = (PIN_W + 1)'(NUM_PINS);

  logic chk_unused;
  assign chk_unused = ^{irq_i, pend_o};

  p_pin0_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o[0]);

  for (genvar p = 3; p < LIMP; p++) begin : g_lvl
    p_level_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_vec[p] && irq_i[p] |=> pend_o[p]);
    p_level_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_vec[p] && !irq_i[p] |=> !pend_o[p]);
  end

  p_wr_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && ({1'b0, cfg_addr_i} < NP) |=> svc_valid_o);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_valid_o && !svc_ready_i |=> svc_valid_o);

  p_tmr_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_armed && (tmr_cnt == '0) |=> svc_valid_o && !tmr_armed);

  p_tmr_nolater_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_armed && (tmr_cnt != '0) |=> tmr_armed && (tmr_cnt == $past(tmr_cnt) - 1'b1));

endmodule

bind irq_eoi_tracker iet_chk #(
  .NUM_IN(NUM_IN), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .TW(TW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .pend_o      (pend_o),
  .svc_valid_o (svc_valid_o),
  .svc_ready_i (svc_ready_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .trig_vec    (trig_vec),
  .tmr_armed   (tmr_armed),
  .tmr_cnt     (tmr_cnt)
);

// File: tb/irq_eoi_tracker_tb_top.sv
module irq_eoi_tracker_tb_top;

  localparam int NIN = 26;
  localparam int NP  = 24;
  localparam int LIM = 5;
  localparam int D   = 40;
  localparam int PW  = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NIN-1:0] irq = '0;
  logic           eoi_v = 1'b0;
  logic [7:0]     eoi_vec = '0;
  logic           dlv_v = 1'b0;
  logic [PW-1:0]  dlv_pin = '0;
  logic           we = 1'b0;
  logic [PW-1:0]  addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic [NP-1:0]  pend;
  logic           svc;
  logic           ready = 1'b0;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  cmp_en = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  irq_eoi_tracker #(.NUM_IN(NIN), .NUM_PINS(NP), .STORM_LIM(LIM), .DEFER_CYC(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .eoi_valid_i(eoi_v), .eoi_vec_i(eoi_vec),
    .dlv_valid_i(dlv_v), .dlv_pin_i(dlv_pin), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .pend_o(pend), .svc_valid_o(svc),
    .svc_ready_i(ready)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0]    m_ent [NP];
  logic [NP-1:0]  m_pend;
  int             m_cnt [NP];
  int             m_tl;
  bit             m_svc;
  logic [NIN-1:0] m_prev;

  function automatic bit line_of(input logic [NIN-1:0] v, input int p);
    if (p == 0) return 1'b0;
    if (p == 2) return v[0] | v[2];
    return v[p];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_ent[p] = 32'h0000_4000; m_cnt[p] = 0; end
      m_pend = '0; m_tl = -1; m_svc = 0; m_prev = '0;
    end else begin
      bit req, dfr, fire;
      req = 0; dfr = 0;
      for (int p = 0; p < NP; p++) begin
        bit lv, rs, trig, msk, rir, eh, ra, st, dh, wr, r2;
        lv   = line_of(irq, p);
        rs   = lv && !line_of(m_prev, p);
        trig = m_ent[p][13]; msk = m_ent[p][14]; rir = m_ent[p][12];
        eh   = eoi_v && (m_ent[p][7:0] == eoi_vec) && trig && rir;
        ra   = eh && !msk && m_pend[p];
        st   = ra && (m_cnt[p] + 1 == LIM);
        dh   = dlv_v && (dlv_pin == PW'(p)) && m_pend[p] && !msk;
        wr   = we && (addr == PW'(p));
        if (trig ? (rs && !rir) : (rs && !msk)) req = 1;
        if (ra && !st) req = 1;
        if (wr) req = 1;
        if (st) dfr = 1;
        if (wr) m_cnt[p] = 0;
        else if (eh) m_cnt[p] = (ra && !st) ? m_cnt[p] + 1 : 0;
        r2 = eh ? 1'b0 : ((dh && trig) ? 1'b1 : rir);
        m_pend[p] = trig ? lv : ((m_pend[p] && !dh) || (rs && !msk));
        if (wr) begin
          m_ent[p] = wdata & 32'hFFFF_6FFF;
          m_ent[p][12] = wdata[13] & r2;
        end else m_ent[p][12] = r2;
      end
      fire = (m_tl == 0);
      if (fire) req = 1;
      if (m_tl < 0) begin if (dfr) m_tl = D - 1; end
      else if (m_tl == 0) m_tl = -1;
      else m_tl = m_tl - 1;
      m_svc = (m_svc && !ready) || req;
      m_prev = irq;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (cmp_en && !done) begin
      logic [31:0] er;
      er = (addr < PW'(NP)) ? m_ent[addr] : 32'h0;
      chk(pend === m_pend, "R2/R3/R4 model pending", 32'(pend), 32'(m_pend));
      chk(svc === m_svc, "R11 model service request", 32'(svc), 32'(m_svc));
      chk(rdata === er, "R10 model entry read", rdata, er);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(negedge clk); endtask
  task automatic wr(input int p, input logic [31:0] d);
    we = 1; addr = PW'(p); wdata = d; step(); we = 0;
  endtask
  task automatic dlv(input int p);
    dlv_v = 1; dlv_pin = PW'(p); step(); dlv_v = 0;
  endtask
  task automatic eoi(input logic [7:0] v);
    eoi_v = 1; eoi_vec = v; step(); eoi_v = 0;
  endtask
  task automatic acc(); ready = 1; step(); ready = 0; endtask
  task automatic rd(input int p, output logic [31:0] d);
    addr = PW'(p); #1; d = rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int first;
    repeat (3) step();
    rst_n = 1; cmp_en = 1;

    // R12 reset state
    chk(pend == '0, "R12 pending after reset", 32'(pend), 0);
    chk(svc == 0, "R12 svc after reset", 32'(svc), 0);
    rd(5, d); chk(d == 32'h0000_4000, "R12 entry reset value", d, 32'h0000_4000);

    // R10 write: flag and reserved bit not writable
    wr(3, 32'hABCD_B033);
    chk(svc == 1, "R10 write requests service", 32'(svc), 1);
    rd(3, d); chk(d == 32'hABCD_2033, "R10 read-only bits", d, 32'hABCD_2033);
    acc(); chk(svc == 0, "R11 cleared after accept", 32'(svc), 0);
    wr(27, 32'hFFFF_FFFF);
    chk(svc == 0, "R10 out-of-range write no request", 32'(svc), 0);
    rd(27, d); chk(d == 0, "R10 out-of-range read", d, 0);

    // R2 level pin
    irq[3] = 1; step();
    chk(pend[3] == 1, "R2 level pending", 32'(pend[3]), 1);
    chk(svc == 1, "R2 level rise request", 32'(svc), 1);
    step(); chk(svc == 1, "R11 held under back-pressure", 32'(svc), 1);
    acc(); dlv(3);
    rd(3, d); chk(d == 32'hABCD_3033, "R4 delivery sets flag", d, 32'hABCD_3033);
    irq[3] = 0; step(); chk(pend[3] == 0, "R2 level falls", 32'(pend[3]), 0);
    irq[3] = 1; step();
    chk(pend[3] == 1, "R2 level re-rise pending", 32'(pend[3]), 1);
    chk(svc == 0, "R2 flag blocks request", 32'(svc), 0);

    // R5 / R6 EOI
    eoi(8'h34);
    rd(3, d); chk(d == 32'hABCD_3033, "R5 vector mismatch keeps flag", d, 32'hABCD_3033);
    chk(svc == 0, "R5 mismatch no request", 32'(svc), 0);
    eoi(8'h33);
    rd(3, d); chk(d == 32'hABCD_2033, "R5 matching EOI clears flag", d, 32'hABCD_2033);
    chk(svc == 1, "R6 re-assert request", 32'(svc), 1);
    acc();

    // R1 steering
    wr(2, 32'h0000_0022); acc();
    irq[0] = 1; step();
    chk(pend[2] == 1, "R1 line 0 drives pin 2", 32'(pend[2]), 1);
    chk(pend[0] == 0, "R1 pin 0 idle", 32'(pend[0]), 0);
    irq[0] = 0; acc(); dlv(2);
    chk(pend[2] == 0, "R4 edge delivery clears pending", 32'(pend[2]), 0);
    irq[25] = 1; step();
    chk(pend == 24'h000008, "R1 high line ignored", 32'(pend), 32'h8);
    chk(svc == 0, "R1 high line no request", 32'(svc), 0);
    irq[25] = 0;

    // R3 edge pin masking
    irq[4] = 1; step();
    chk(pend[4] == 0, "R3 masked edge dropped", 32'(pend[4]), 0);
    chk(svc == 0, "R3 masked edge no request", 32'(svc), 0);
    irq[4] = 0; wr(4, 32'h0000_0044); acc();
    chk(pend[4] == 0, "R3 masked edge not remembered", 32'(pend[4]), 0);
    irq[4] = 1; step();
    chk(pend[4] == 1, "R3 unmasked edge pending", 32'(pend[4]), 1);
    chk(svc == 1, "R3 unmasked edge request", 32'(svc), 1);
    irq[4] = 0; acc(); dlv(4);
    chk(pend[4] == 0, "R4 edge delivered", 32'(pend[4]), 0);
    dlv(5);
    rd(5, d); chk(d == 32'h0000_4000, "R4 report on idle pin ignored", d, 32'h0000_4000);

    // R8 write resets counter, R7 storm deferral
    wr(3, 32'hABCD_2033); acc();
    for (int i = 1; i <= LIM; i++) begin
      dlv(3); eoi(8'h33);
      if (i < LIM) begin
        chk(svc == 1, "R8 re-assert immediate before limit", 32'(svc), 1);
        acc();
      end
    end
    chk(svc == 0, "R7 limit re-assert deferred", 32'(svc), 0);
    repeat (D - 1) step();
    chk(svc == 0, "R7 no service before deadline", 32'(svc), 0);
    step();
    chk(svc == 1, "R7 service at deadline", 32'(svc), 1);
    acc(); dlv(3); eoi(8'h33);
    chk(svc == 1, "R7 counter restarted", 32'(svc), 1);
    acc();

    // R8 EOI on dead line resets counter
    dlv(3); irq[3] = 0; step(); eoi(8'h33);
    chk(svc == 0, "R8 EOI dead line no request", 32'(svc), 0);
    irq[3] = 1; step();
    chk(svc == 1, "R2 rise after flag cleared", 32'(svc), 1);
    acc();
    for (int i = 1; i < LIM; i++) begin
      dlv(3); eoi(8'h33);
      chk(svc == 1, "R8 count restarted from zero", 32'(svc), 1);
      acc();
    end
    dlv(3); eoi(8'h33); // brings pin 3 to the limit: deferred
    repeat (D + 2) step();
    acc();

    // R9 shared countdown not pushed later
    wr(5, 32'h0000_2055); acc();
    irq[5] = 1; step(); acc();
    for (int i = 1; i < LIM; i++) begin
      dlv(3); dlv(5); eoi(8'h33); eoi(8'h55); acc();
    end
    dlv(3); dlv(5); eoi(8'h33);
    first = 0;
    for (int k = 1; k <= D + 3; k++) begin
      if (k == 10) begin eoi_v = 1; eoi_vec = 8'h55; end
      step(); eoi_v = 0;
      if (svc && first == 0) first = k;
    end
    chk(first == D, "R9 deadline kept by shared timer", 32'(first), 32'(D));
    acc();
    step();

    finish_run();
  end

endmodule